// File: doc/BRIEF.md
# Level-Sensed DMA Request Acceptance Controller

This block decides when one DMA channel, working in single-address mode, may run a transfer. The request comes from an active-low pin that is sensed by level rather than by edge. A configuration write turns the channel on and loads a transfer count. From the next clock onward the controller looks at the synchronized pin on every cycle. When it sees a low level it latches one pending request. It then waits for the processor to offer a bus break, asks for the bus, and runs exactly one single cycle once the grant arrives.

Acceptance is closed from the moment a request is latched until the single cycle reports completion. As a result, a pin held low for a long time turns into one request per single cycle and never into a burst. Each completed cycle takes one from the count. When the count reaches zero, the channel switches itself off and raises an end flag. A write that disables the channel drops any request that has not yet reached its single cycle.

The input `rst_n` is expected to come from a reset synchronizer elsewhere on the chip. It is asserted asynchronously and released on a clock edge.

Top module: `dma_lvlreq_ctrl`

## Requirements
- R1: After reset, `bus_req`, `single_act`, `accept_open`, `req_held`, `chan_en` and `xfer_end` are all 0 and `xfer_cnt` is 0.
- R2: A write with `cfg_we`=1, `cfg_en`=1 and a nonzero `cfg_count` sets `chan_en`=1, sets `xfer_cnt`=`cfg_count` and sets `accept_open`=1 at the edge that captures the write. Pin sampling starts at the following edge.
- R3: `req_n` passes through two synchronizer flops. While `accept_open`=1, a low level applied before edge k makes `req_held` rise at edge k+2, and `accept_open` falls at that same edge.
- R4: While acceptance is open, a high level on `req_n` latches nothing: `req_held` stays 0 and `accept_open` stays 1.
- R5: A held request waits for `bus_break`=1, however long that takes. At the edge that samples the break, `req_held` clears and `bus_req` rises.
- R6: `single_act` rises at the edge that samples `bus_gnt`=1 while the bus is being requested. A grant that is already high when the request starts is used at once. At least 2 cycles separate the rise of `req_held` from the rise of `single_act`.
- R7: `accept_open` stays 0 and `req_held` stays 0 for the whole single cycle, even if `req_n` is low. The cycle ends at the edge that samples `single_done`=1. There follows one cycle with acceptance closed, after which acceptance reopens. A pin that stays low is latched again at the edge after that.
- R8: Each completed single cycle lowers `xfer_cnt` by 1. When it reaches 0, `chan_en` goes to 0, `xfer_end` goes to 1, and later low levels on `req_n` are ignored.
- R9: A write with `cfg_we`=1 and `cfg_en`=0 clears `chan_en`. Before the single cycle, it drops any held request and returns the block to idle at the next edge. During a single cycle, the cycle is allowed to finish and the block then goes idle.
- R10: An enabling write with `cfg_count`=0 leaves `chan_en`=0 and `accept_open`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cfg_we | input | 1 | One-cycle strobe for the channel control write |
| cfg_en | input | 1 | Enable value carried by the write |
| cfg_count | input | CNT_W | Transfer count carried by an enabling write |
| req_n | input | 1 | Active-low level-sensed transfer request pin |
| bus_break | input | 1 | Processor offers a bus break this cycle |
| bus_gnt | input | 1 | Bus granted to the DMA channel |
| single_done | input | 1 | The current single cycle completes this cycle |
| bus_req | output | 1 | Bus request, high from activation to the end of the single cycle |
| single_act | output | 1 | Single cycle in progress |
| accept_open | output | 1 | Pin sampling is open this cycle |
| req_held | output | 1 | A request is latched and waiting for a bus break |
| chan_en | output | 1 | Channel enabled |
| xfer_end | output | 1 | Transfer count has run out |
| xfer_cnt | output | CNT_W | Remaining transfer count |

## Verification
A wrong controller state becomes visible at the ports within one edge. The `accept_open`, `req_held`, `bus_req` and `single_act` outputs are decoded directly from the state register. A state that reopens acceptance too early therefore shows up as a second `req_held` pulse while `single_act` is still high. A state that skips the bus request shows up as `single_act` rising without a preceding `bus_req` cycle. A counter fault shows up in `xfer_cnt` on the edge that ends the single cycle, and in `chan_en` or `xfer_end` on the cycle where the count should reach zero.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACCEPT = 3'd1,
    ST_HELD   = 3'd2,
    ST_BUSREQ = 3'd3,
    ST_SINGLE = 3'd4,
    ST_RESUME = 3'd5
  } dlr_state_t;
endpackage

// File: rtl/dlr_sync.sv
module dlr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dlr_chan_reg.sv
module dlr_chan_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             dec,
  output logic             arm,
  output logic             drop,
  output logic             chan_en,
  output logic             xfer_end,
  output logic             last,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             en_d, end_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign arm    = cfg_we && cfg_en && (cfg_count != '0);
  assign drop   = cfg_we && !arm;
  assign last   = (cnt == ONE);
  assign cnt_ce = arm || dec;

  always_comb begin
    cnt_d = cnt;
    if (arm)      cnt_d = cfg_count;
    else if (dec) cnt_d = cnt - ONE;
  end

  always_comb begin
    en_d  = chan_en;
    end_d = xfer_end;
    if (cfg_we) begin
      en_d = arm;
      if (arm) end_d = 1'b0;
    end else if (dec && last) begin
      en_d  = 1'b0;
      end_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      chan_en  <= 1'b0;
      xfer_end <= 1'b0;
    end else begin
      if (cnt_ce) cnt <= cnt_d;
      chan_en  <= en_d;
      xfer_end <= end_d;
    end
  end

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !arm) |=> (cnt == $past(cnt) - ONE));

  // R8
  end_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_end) |-> !chan_en);
endmodule

// File: rtl/dlr_fsm.sv
module dlr_fsm
  import dlr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic drop,
  input  logic chan_en,
  input  logic last,
  input  logic req_s,
  input  logic bus_break,
  input  logic bus_gnt,
  input  logic single_done,
  output logic accept_open,
  output logic req_held,
  output logic bus_req,
  output logic single_act,
  output logic dec
);
  dlr_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (arm) state_d = ST_ACCEPT;
      ST_ACCEPT: begin
        if (drop)        state_d = ST_IDLE;
        else if (!req_s) state_d = ST_HELD;
      end
      ST_HELD: begin
        if (drop)           state_d = ST_IDLE;
        else if (bus_break) state_d = ST_BUSREQ;
      end
      ST_BUSREQ: begin
        if (drop)         state_d = ST_IDLE;
        else if (bus_gnt) state_d = ST_SINGLE;
      end
      ST_SINGLE: begin
        if (single_done)
          state_d = (last || drop || !chan_en) ? ST_IDLE : ST_RESUME;
      end
      ST_RESUME: state_d = (drop || !chan_en) ? ST_IDLE : ST_ACCEPT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept_open = (state_q == ST_ACCEPT);
  assign req_held    = (state_q == ST_HELD);
  assign single_act  = (state_q == ST_SINGLE);
  assign bus_req     = (state_q == ST_BUSREQ) || single_act;
  assign dec         = single_act && single_done;

  // R3
  held_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_held) |-> ($past(accept_open) && !$past(req_s)));

  // R5
  break_before_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(req_held) && $past(bus_break)));

  // R6
  gnt_before_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(single_act) |-> ($past(bus_gnt) && $past(bus_req)));

  // R7
  single_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_act) |-> $past(single_done));

  // R7
  no_reopen_from_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_act) |-> !accept_open);
endmodule

// File: rtl/dma_lvlreq_ctrl.sv
module dma_lvlreq_ctrl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_n,
  input  logic             bus_break,
  input  logic             bus_gnt,
  input  logic             single_done,
  output logic             bus_req,
  output logic             single_act,
  output logic             accept_open,
  output logic             req_held,
  output logic             chan_en,
  output logic             xfer_end,
  output logic [CNT_W-1:0] xfer_cnt
);
  logic req_s, arm, drop, last, dec;

  dlr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (req_n),
    .dout (req_s)
  );

  dlr_chan_reg #(.CNT_W(CNT_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_en   (cfg_en),
    .cfg_count(cfg_count),
    .dec      (dec),
    .arm      (arm),
    .drop     (drop),
    .chan_en  (chan_en),
    .xfer_end (xfer_end),
    .last     (last),
    .cnt      (xfer_cnt)
  );

  dlr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .drop       (drop),
    .chan_en    (chan_en),
    .last       (last),
    .req_s      (req_s),
    .bus_break  (bus_break),
    .bus_gnt    (bus_gnt),
    .single_done(single_done),
    .accept_open(accept_open),
    .req_held   (req_held),
    .bus_req    (bus_req),
    .single_act (single_act),
    .dec        (dec)
  );
endmodule

// File: tb/dma_lvlreq_ctrl_tb.sv
module dma_lvlreq_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_en, req_n, bus_break, bus_gnt, single_done;
  logic [CNT_W-1:0] cfg_count;
  logic bus_req, single_act, accept_open, req_held, chan_en, xfer_end;
  logic [CNT_W-1:0] xfer_cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [CNT_W:0] exp_q[$];
  logic prev_single = 1'b0;

  always #5 clk = ~clk;

  dma_lvlreq_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_count(cfg_count), .req_n(req_n), .bus_break(bus_break),
    .bus_gnt(bus_gnt), .single_done(single_done), .bus_req(bus_req),
    .single_act(single_act), .accept_open(accept_open), .req_held(req_held),
    .chan_en(chan_en), .xfer_end(xfer_end), .xfer_cnt(xfer_cnt)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_cfg(input logic en, input logic [CNT_W-1:0] cnt);
    cfg_we = 1'b1; cfg_en = en; cfg_count = cnt;
    step();
    cfg_we = 1'b0; cfg_en = 1'b0; cfg_count = '0;
  endtask

  // driver: queue the expected count/end after completion, then finish the cycle
  task automatic finish_single(input int exp_cnt, input logic exp_end);
    exp_q.push_back({exp_end, CNT_W'(exp_cnt)});
    single_done = 1'b1;
    step();
    single_done = 1'b0;
  endtask

  // monitor: at the end of every single cycle compare against the queue (R8)
  always @(negedge clk) begin
    if (rst_n && prev_single && !single_act) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected cycle end: actual cnt %0d expected none", xfer_cnt);
      end else begin
        logic [CNT_W:0] e;
        e = exp_q.pop_front();
        check("R8", "count after single", int'(xfer_cnt), int'(e[CNT_W-1:0]));
        check("R8", "end flag after single", int'(xfer_end), int'(e[CNT_W]));
      end
    end
    prev_single <= single_act;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0; cfg_count = '0;
    req_n = 1'b1; bus_break = 1'b0; bus_gnt = 1'b0; single_done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step();
    // R1
    check("R1", "bus_req", bus_req, 0);
    check("R1", "single_act", single_act, 0);
    check("R1", "accept_open", accept_open, 0);
    check("R1", "chan_en", chan_en, 0);
    check("R1", "xfer_end", xfer_end, 0);
    check("R1", "xfer_cnt", xfer_cnt, 0);

    // R10: zero count does not enable
    write_cfg(1'b1, 0);
    check("R10", "chan_en", chan_en, 0);
    check("R10", "accept_open", accept_open, 0);

    // R2
    write_cfg(1'b1, 3);
    check("R2", "chan_en", chan_en, 1);
    check("R2", "accept_open", accept_open, 1);
    check("R2", "xfer_cnt", xfer_cnt, 3);

    // R4: high level latches nothing
    step(5);
    check("R4", "req_held", req_held, 0);
    check("R4", "accept_open", accept_open, 1);

    // R3: two synchronizer flops then the sample
    req_n = 1'b0;
    step(2);
    check("R3", "req_held before sync delay", req_held, 0);
    step();
    check("R3", "req_held after sync delay", req_held, 1);
    check("R3", "accept_open closed", accept_open, 0);

    // R5: waits for the break
    step(3);
    check("R5", "held while no break", req_held, 1);
    check("R5", "bus_req while no break", bus_req, 0);
    bus_break = 1'b1;
    step();
    bus_break = 1'b0;
    check("R5", "held cleared", req_held, 0);
    check("R5", "bus_req", bus_req, 1);

    // R6: waits for grant
    step(2);
    check("R6", "single without grant", single_act, 0);
    bus_gnt = 1'b1;
    step();
    bus_gnt = 1'b0;
    check("R6", "single on grant", single_act, 1);

    // R7: closed during single with pin low
    step(2);
    check("R7", "accept_open in single", accept_open, 0);
    check("R7", "req_held in single", req_held, 0);
    finish_single(2, 1'b0);
    check("R7", "single ended", single_act, 0);
    check("R7", "accept closed after end", accept_open, 0);
    step();
    check("R7", "accept reopened", accept_open, 1);
    step();
    check("R7", "low pin latched again", req_held, 1);

    // R6: grant already high, break at once; 2-cycle minimum
    bus_gnt = 1'b1; bus_break = 1'b1;
    step();
    bus_break = 1'b0;
    check("R6", "bus_req with early grant", bus_req, 1);
    check("R6", "single not yet", single_act, 0);
    step();
    bus_gnt = 1'b0;
    check("R6", "single with standing grant", single_act, 1);
    finish_single(1, 1'b0);
    step(2);
    check("R7", "latched again", req_held, 1);

    // R9: disable while held
    write_cfg(1'b0, 0);
    check("R9", "held dropped", req_held, 0);
    check("R9", "chan_en", chan_en, 0);
    check("R9", "bus_req", bus_req, 0);
    step(4);
    check("R9", "no accept after disable", accept_open, 0);
    check("R9", "count kept", xfer_cnt, 1);

    // R9: disable during single lets it finish
    write_cfg(1'b1, 2);
    step();
    check("R9", "held after re-enable", req_held, 1);
    bus_break = 1'b1; bus_gnt = 1'b1;
    step(2);
    bus_break = 1'b0; bus_gnt = 1'b0;
    check("R9", "in single", single_act, 1);
    write_cfg(1'b0, 0);
    check("R9", "single continues after disable", single_act, 1);
    check("R9", "chan_en cleared", chan_en, 0);
    finish_single(1, 1'b0);
    step(3);
    check("R9", "idle after finish", accept_open | req_held | bus_req, 0);

    // R8: last transfer ends the channel
    write_cfg(1'b1, 1);
    step();
    bus_break = 1'b1; bus_gnt = 1'b1;
    step(2);
    bus_break = 1'b0; bus_gnt = 1'b0;
    check("R8", "in last single", single_act, 1);
    finish_single(0, 1'b1);
    check("R8", "chan_en off", chan_en, 0);
    check("R8", "xfer_end", xfer_end, 1);
    step(5);
    check("R8", "low pin ignored", req_held | accept_open, 0);
    check("R8", "queue drained", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule